// File: doc/BRIEF.md
# Accelerator Control and Power Register Block

This block is the top-level control register file of a graphics accelerator. Software reaches it through a plain 32-bit write port (enable, byte address, data) and a combinational read port (address in, data out). It has three parts. The first is a command register that acts on a small numbered set of commands. The second is a bank of per-domain power registers for four unit groups: shader cores, tiler, L2 and L3. Each domain keeps 64-bit present and ready masks, split into low and high 32-bit words. The third is an interrupt unit with raw, clear, mask and masked-status registers, which drives a level interrupt line.

There are no real engines behind the commands. A reset, a counter sample or a cache maintenance command only posts its completion interrupt in the same cycle as the write. Power-on requests take effect at once, filtered by the present masks, which are fixed when the block is built.

Address map (byte offsets). Interrupt raw 0x00, clear 0x04, mask 0x08, status 0x0C, command 0x10. Domain index d is 0 for shader, 1 for tiler, 2 for L2 and 3 for L3. Word index w is 0 for low and 1 for high. Per-domain words are at base + d*8 + w*4, with present at base 0x40, ready at 0x60, power-on at 0x80 and power-off at 0xA0. Interrupt bits are: 0 one-domain power change, 1 all-domain power change, 2 reset done, 3 sample done, 4 cache clean done.

Top module: `accel_ctrl_regs`

## Requirements
- R1: Writing command code 0, 3, 5 or 6 to 0x10 changes no register and raises no interrupt.
- R2: A command value of 9 or above written to 0x10 changes no register and raises no interrupt.
- R3: Command 1 or 2 at 0x10 sets every ready word and the mask (0x08) to zero, then leaves raw (0x00) equal to exactly bit 2 (reset done).
- R4: Command 4 at 0x10 sets raw bit 3 (sample done).
- R5: Command 7 or command 8 at 0x10 sets raw bit 4 (cache clean done).
- R6: A write of V to power-on word 0x80+d*8+w*4 makes ready word 0x60+d*8+w*4 equal to its old value OR (V AND the present word at 0x40+d*8+w*4).
- R7: A write of V to power-off word 0xA0+d*8+w*4 clears the bits of V in ready word 0x60+d*8+w*4, whatever present holds.
- R8: Every power-on or power-off write sets raw bits 0 and 1.
- R9: Writes to undecoded addresses and to the read-only raw, status, present and ready words change nothing. Undecoded reads return 0.
- R10: Writing 1s to clear (0x04) clears those raw bits and keeps the others.
- R11: Mask (0x08) is read-write on bits 4:0. Status (0x0C) reads raw AND mask. The irq output is high exactly when status is nonzero.
- R12: After rst_n is asserted, raw, mask and all ready words are zero and irq is low. Present words read the build-time parameter values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq | output | 1 | Level interrupt, high while masked status is nonzero |

## Verification
Assertions check several rules on every cycle. A ready word never holds a bit outside its present word. Power-off bits are gone in the cycle after the write. Every power write posts both power-change bits. Cleared raw bits stay cleared when nothing raises them in that cycle. A reset command leaves only the reset-done bit. An ignored command disturbs neither raw nor mask. Only the bench's scenarios can show the address map itself, the exact OR-accumulation into ready words across low and high halves of different domains, and the command-to-bit mapping. They also show that writes to read-only and unmapped addresses are discarded at the read port, and how the irq line behaves as mask and clear are written.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
   localparam int DW       = 32;
   localparam int AW       = 8;
   localparam int IRQ_W    = 5;
   localparam int NUM_CMDS = 9;

   // interrupt bit positions
   localparam int IB_PWR_ONE = 0;
   localparam int IB_PWR_ALL = 1;
   localparam int IB_RST     = 2;
   localparam int IB_SMPL    = 3;
   localparam int IB_CLEAN   = 4;

   // register offsets
   localparam logic [AW-1:0] A_RAW    = 8'h00;
   localparam logic [AW-1:0] A_CLR    = 8'h04;
   localparam logic [AW-1:0] A_MASK   = 8'h08;
   localparam logic [AW-1:0] A_STAT   = 8'h0C;
   localparam logic [AW-1:0] A_CMD    = 8'h10;
   localparam logic [AW-1:0] A_PRES   = 8'h40;
   localparam logic [AW-1:0] A_READY  = 8'h60;
   localparam logic [AW-1:0] A_PWRON  = 8'h80;
   localparam logic [AW-1:0] A_PWROFF = 8'hA0;
   localparam int            RGN_LG   = 5;   // 32-byte power regions

   typedef enum logic [3:0] {
      CMD_NOP       = 4'd0,
      CMD_SOFT_RST  = 4'd1,
      CMD_HARD_RST  = 4'd2,
      CMD_CNT_CLR   = 4'd3,
      CMD_CNT_SMPL  = 4'd4,
      CMD_CYC_START = 4'd5,
      CMD_CYC_STOP  = 4'd6,
      CMD_CLEAN     = 4'd7,
      CMD_CLEAN_INV = 4'd8
   } cmd_e;
endpackage

// File: rtl/accel_cmd_decode.sv
module accel_cmd_decode
   import accel_ctrl_pkg::*;
#(
   parameter int CW = DW
) (
   input  logic          cmd_we,
   input  logic [CW-1:0] cmd_val,
   output logic          soft_clr,
   output logic [IRQ_W-1:0] raise
);
   logic known;
   cmd_e code;

   always_comb begin
      known    = cmd_we && (cmd_val < CW'(NUM_CMDS));
      code     = cmd_e'(cmd_val[3:0]);
      soft_clr = 1'b0;
      raise    = '0;
      if (known) begin
         unique case (code)
            CMD_SOFT_RST, CMD_HARD_RST: begin
               soft_clr      = 1'b1;
               raise[IB_RST] = 1'b1;
            end
            CMD_CNT_SMPL:            raise[IB_SMPL]  = 1'b1;
            CMD_CLEAN, CMD_CLEAN_INV: raise[IB_CLEAN] = 1'b1;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/accel_pwr_word.sv
module accel_pwr_word #(
   parameter int          W       = 32,
   parameter logic [W-1:0] PRESENT = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         soft_clr,
   input  logic         on_we,
   input  logic         off_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] ready
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ready <= '0;
      else if (soft_clr) ready <= '0;
      else if (on_we)    ready <= ready | (wdata & PRESENT);
      else if (off_we)   ready <= ready & ~wdata;
   end

   AST_READY_IN_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      (ready & ~PRESENT) == '0); // R6
   AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (off_we && !soft_clr) |=> (ready & $past(wdata)) == '0); // R7
endmodule

// File: rtl/accel_irq_unit.sv
module accel_irq_unit
   import accel_ctrl_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_clr,
   input  logic [IRQ_W-1:0] raise,
   input  logic             clr_we,
   input  logic [IRQ_W-1:0] clr_bits,
   input  logic             mask_we,
   input  logic [IRQ_W-1:0] mask_bits,
   output logic [IRQ_W-1:0] raw,
   output logic [IRQ_W-1:0] mask,
   output logic             irq
);
   logic [IRQ_W-1:0] raw_nxt;

   always_comb begin
      raw_nxt = raw;
      if (soft_clr) raw_nxt = '0;
      if (clr_we)   raw_nxt = raw_nxt & ~clr_bits;
      raw_nxt = raw_nxt | raise;   // a raise survives a same-cycle clear
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw  <= '0;
         mask <= '0;
      end else begin
         raw <= raw_nxt;
         if (soft_clr)     mask <= '0;
         else if (mask_we) mask <= mask_bits;
      end
   end

   assign irq = |(raw & mask);

   AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && raise == '0) |=> (raw & $past(clr_bits)) == '0); // R10
   AST_RESET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (raw == IRQ_W'(1 << IB_RST)) && (mask == '0)); // R3
endmodule

// File: rtl/accel_ctrl_regs.sv
module accel_ctrl_regs
   import accel_ctrl_pkg::*;
#(
   parameter int NUM_DOM = 4,
   parameter logic [NUM_DOM-1:0][2*DW-1:0] PRESENT_MASK = {
      64'h0000_0000_0000_0000,   // L3
      64'h0000_0000_0000_0001,   // L2
      64'h0000_0000_0000_0001,   // tiler
      64'h0000_0003_0000_00FF }  // shader
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic          irq
);
   localparam int NUM_WORDS = NUM_DOM * 2;
   localparam int IDX_W     = RGN_LG - 2;

   if (NUM_DOM < 1 || NUM_DOM > 4) begin : g_bad_dom
      $error("NUM_DOM must be 1..4 to fit a 32-byte region");
   end
   if (DW != 32) begin : g_bad_dw
      $error("register width must be 32");
   end

   function automatic logic rgn_hit(input logic [AW-1:0] a, input logic [AW-1:0] base);
      return (a[AW-1:RGN_LG] == base[AW-1:RGN_LG]) && (a[1:0] == 2'b00)
             && (int'(a[RGN_LG-1:3]) < NUM_DOM);
   endfunction

   // write decode
   logic wr_cmd, wr_clr, wr_mask, wr_on, wr_off;
   logic [IDX_W-1:0] wr_idx;

   assign wr_cmd  = wr_en && (wr_addr == A_CMD);
   assign wr_clr  = wr_en && (wr_addr == A_CLR);
   assign wr_mask = wr_en && (wr_addr == A_MASK);
   assign wr_on   = wr_en && rgn_hit(wr_addr, A_PWRON);
   assign wr_off  = wr_en && rgn_hit(wr_addr, A_PWROFF);
   assign wr_idx  = wr_addr[RGN_LG-1:2];

   // command dispatch
   logic             soft_clr;
   logic [IRQ_W-1:0] cmd_raise, raise;

   accel_cmd_decode #(.CW(DW)) u_cmd (
      .cmd_we  (wr_cmd),
      .cmd_val (wr_data),
      .soft_clr(soft_clr),
      .raise   (cmd_raise)
   );

   always_comb begin
      raise = cmd_raise;
      if (wr_on || wr_off) begin
         raise[IB_PWR_ONE] = 1'b1;
         raise[IB_PWR_ALL] = 1'b1;
      end
   end

   // power domains
   logic [DW-1:0] ready_w [NUM_WORDS];
   logic [DW-1:0] pres_w  [NUM_WORDS];

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      for (genvar w = 0; w < 2; w++) begin : g_word
         localparam int K = d * 2 + w;
         localparam logic [DW-1:0] PW = PRESENT_MASK[d][w*DW +: DW];
         assign pres_w[K] = PW;
         accel_pwr_word #(.W(DW), .PRESENT(PW)) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .soft_clr(soft_clr),
            .on_we   (wr_on  && (int'(wr_idx) == K)),
            .off_we  (wr_off && (int'(wr_idx) == K)),
            .wdata   (wr_data),
            .ready   (ready_w[K])
         );
      end
   end

   // interrupt unit
   logic [IRQ_W-1:0] raw, mask;

   accel_irq_unit u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .raise    (raise),
      .clr_we   (wr_clr),
      .clr_bits (wr_data[IRQ_W-1:0]),
      .mask_we  (wr_mask),
      .mask_bits(wr_data[IRQ_W-1:0]),
      .raw      (raw),
      .mask     (mask),
      .irq      (irq)
   );

   // read mux
   logic [IDX_W-1:0] rd_idx;
   assign rd_idx = rd_addr[RGN_LG-1:2];

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_RAW)                rd_data = DW'(raw);
      else if (rd_addr == A_MASK)          rd_data = DW'(mask);
      else if (rd_addr == A_STAT)          rd_data = DW'(raw & mask);
      else if (rgn_hit(rd_addr, A_PRES))   rd_data = pres_w[rd_idx];
      else if (rgn_hit(rd_addr, A_READY))  rd_data = ready_w[rd_idx];
   end

   AST_PWR_POSTS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_on || wr_off) |=> raw[IB_PWR_ONE] && raw[IB_PWR_ALL]); // R8
   AST_BAD_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && wr_data >= DW'(NUM_CMDS)) |=> $stable(raw) && $stable(mask)); // R2
   AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (raw != '0) && (mask != '0)); // R11
endmodule

// File: tb/sim_accel_ctrl_regs.sv
module sim_accel_ctrl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;   // 250 MHz

   accel_ctrl_regs u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   typedef struct packed {
      logic        we;
      logic [7:0]  wa;
      logic [31:0] wd;
      logic [7:0]  ra;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NVEC = 34;
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 8'h08, 32'h1F,       8'h08, 32'h1F, 8'd11}, // R11 mask rw
      '{1'b1, 8'h80, 32'hFFFF,     8'h60, 32'hFF, 8'd6},  // R6 shader lo
      '{1'b0, 8'h00, 32'h0,        8'h00, 32'h03, 8'd8},  // R8
      '{1'b1, 8'h04, 32'h3,        8'h00, 32'h00, 8'd10}, // R10
      '{1'b1, 8'h84, 32'hF,        8'h64, 32'h03, 8'd6},  // R6 shader hi
      '{1'b1, 8'hA0, 32'h0F,       8'h60, 32'hF0, 8'd7},  // R7
      '{1'b1, 8'hBC, 32'hFFFFFFFF, 8'h7C, 32'h00, 8'd7},  // R7 off w/o present
      '{1'b1, 8'h04, 32'h1,        8'h00, 32'h02, 8'd10}, // R10 partial
      '{1'b1, 8'h04, 32'h2,        8'h0C, 32'h00, 8'd11}, // R11
      '{1'b1, 8'h10, 32'h4,        8'h00, 32'h08, 8'd4},  // R4
      '{1'b1, 8'h10, 32'h7,        8'h00, 32'h18, 8'd5},  // R5 clean
      '{1'b1, 8'h04, 32'h10,       8'h00, 32'h08, 8'd10}, // R10
      '{1'b1, 8'h10, 32'h8,        8'h00, 32'h18, 8'd5},  // R5 clean+inv
      '{1'b1, 8'h10, 32'h3,        8'h00, 32'h18, 8'd1},  // R1
      '{1'b1, 8'h10, 32'h0,        8'h0C, 32'h18, 8'd1},  // R1
      '{1'b1, 8'h10, 32'h5,        8'h60, 32'hF0, 8'd1},  // R1
      '{1'b1, 8'h10, 32'h6,        8'h00, 32'h18, 8'd1},  // R1
      '{1'b1, 8'h10, 32'h9,        8'h00, 32'h18, 8'd2},  // R2
      '{1'b1, 8'h10, 32'hFFFFFFFF, 8'h60, 32'hF0, 8'd2},  // R2
      '{1'b1, 8'h40, 32'h0,        8'h40, 32'hFF, 8'd9},  // R9 present RO
      '{1'b1, 8'hFC, 32'h1,        8'hFC, 32'h00, 8'd9},  // R9 unmapped
      '{1'b1, 8'h00, 32'hFFFFFFFF, 8'h00, 32'h18, 8'd9},  // R9 raw RO
      '{1'b1, 8'h60, 32'hFFFFFFFF, 8'h60, 32'hF0, 8'd9},  // R9 ready RO
      '{1'b1, 8'h0C, 32'h0,        8'h0C, 32'h18, 8'd9},  // R9 status RO
      '{1'b1, 8'h08, 32'h08,       8'h0C, 32'h08, 8'd11}, // R11
      '{1'b1, 8'h88, 32'h3,        8'h68, 32'h01, 8'd6},  // R6 tiler
      '{1'b1, 8'h10, 32'h1,        8'h00, 32'h04, 8'd3},  // R3 soft
      '{1'b0, 8'h00, 32'h0,        8'h08, 32'h00, 8'd3},  // R3 mask
      '{1'b0, 8'h00, 32'h0,        8'h60, 32'h00, 8'd3},  // R3 ready
      '{1'b0, 8'h00, 32'h0,        8'h68, 32'h00, 8'd3},  // R3 ready
      '{1'b1, 8'h98, 32'hFF,       8'h78, 32'h00, 8'd6},  // R6 L3 absent
      '{1'b1, 8'h10, 32'h2,        8'h00, 32'h04, 8'd3},  // R3 hard
      '{1'b1, 8'h90, 32'h1,        8'h70, 32'h01, 8'd6},  // R6 L2
      '{1'b0, 8'h00, 32'h0,        8'h64, 32'h00, 8'd3}   // R3
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R12 reset state
      rd_chk("R12 raw", 8'h00, 32'h0);
      rd_chk("R12 mask", 8'h08, 32'h0);
      rd_chk("R12 ready", 8'h60, 32'h0);
      rd_chk("R12 present shader lo", 8'h40, 32'hFF);
      rd_chk("R12 present shader hi", 8'h44, 32'h3);
      rd_chk("R12 present tiler", 8'h48, 32'h1);
      rd_chk("R12 present L3", 8'h58, 32'h0);
      check("R12 irq", {31'b0, irq}, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         if (VEC[i].we) wr(VEC[i].wa, VEC[i].wd);
         else @(negedge clk);
         rd_chk($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].ra, VEC[i].exp);
      end

      // R11 irq line; raw is 0x07, mask 0 here
      check("R11 irq masked", {31'b0, irq}, 32'h0);
      wr(8'h08, 32'h04);
      check("R11 irq on", {31'b0, irq}, 32'h1);
      wr(8'h04, 32'h04);
      check("R11 irq off after clear", {31'b0, irq}, 32'h0);
      wr(8'h08, 32'h01);
      check("R11 irq pwr bit", {31'b0, irq}, 32'h1);
      wr(8'h08, 32'h00);
      check("R11 irq mask off", {31'b0, irq}, 32'h0);
      wr(8'h08, 32'h01);
      wr(8'h04, 32'h01);
      check("R11 irq cleared", {31'b0, irq}, 32'h0);
      wr(8'hA0, 32'h0);
      check("R8 irq from pwr off", {31'b0, irq}, 32'h1);

      // R12 hardware reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      rd_chk("R12 raw after rst", 8'h00, 32'h0);
      rd_chk("R12 ready L2 after rst", 8'h70, 32'h0);
      check("R12 irq after rst", {31'b0, irq}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      finish_run();
   end
endmodule